// File: doc/BRIEF.md
# Dual Wiper Register Controller

This block is the register and command core of a two-channel digital potentiometer. A serial front end hands it one instruction byte and one data byte per frame, then marks the end of the frame. Each channel has a volatile 6-bit wiper register. The wiper register drives a one-hot select over 64 taps. Each channel also has four 6-bit backup registers that are treated as non-volatile storage. The commands read and write either kind of register. They also copy values between a wiper and one of its backup registers, for one channel or for both channels at once. One further command opens a stepping mode, in which single pulses move the wiper up or down by one tap.

A backup-register write is held as pending until the frame ends. At that point it is committed, and the block reports busy for a fixed number of system clocks, `PROG_CYCLES`, which stands in for the programming time. While busy is high, the block ignores every command and every step. An active-low write-protect input refuses backup-register writes and leaves wiper writes alone. If write-protect falls while a write is still pending, the pending write is discarded. The backup registers hold their contents through reset. On reset, each wiper reloads from backup register 0 of its own channel.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: The power-on content of backup register i of wiper w is 16*w+5*i+3. Reset does not change the backup registers. While reset is held, and after it is released, wiper w equals its current backup register 0.
- R2: The instruction byte is laid out as bits [7:4] opcode, [3:2] backup index, bit 1 = 0, bit 0 wiper select. Opcode 1001 returns the selected wiper on rd_data, with rd_valid and ack pulsed for one cycle. Bits [7:6] of rd_data are always 0.
- R3: Opcode 1010 loads data bits [5:0] into the selected wiper, and the new value shows on the taps in the cycle after the command. Data bits [7:6] are ignored. The command never raises busy.
- R4: Opcode 1011 reads the selected backup register. Opcode 1100 writes it. The write is committed on frame_stop, and busy then rises in the next cycle and stays high for exactly PROG_CYCLES cycles.
- R5: Opcode 1101 copies the selected backup register into its wiper at once, with no busy. Opcode 1110 copies the selected wiper into the indexed backup register, and this copy behaves as a backup write (R4).
- R6: Opcode 0001 loads both wipers from their backup registers at the given index. Opcode 1000 writes both wipers into their backup registers at that index, as one backup write. Both opcodes ignore bit 0.
- R7: While wp_n is 0, the backup-write opcodes (1100, 1110, 1000) get ack = 0, change no register and start no busy cycle. Wiper writes and reads still get ack = 1.
- R8: If wp_n is 0 in any cycle between an accepted backup-write command and frame_stop, the write is dropped. If wp_n falls after busy has risen, the write still completes.
- R9: While busy is high, command pulses produce no ack and no rd_valid, and change no register. Step pulses are ignored too.
- R10: For each wiper, exactly one of its 64 tap selects is high, namely the one at the wiper's value.
- R11: An instruction with an opcode outside R2–R6 and R12, or with bit 1 set, gets ack = 0. It changes no register and starts no busy cycle.
- R12: Opcode 0010 selects a wiper for stepping until frame_stop. Each step pulse moves that wiper by +1 (step_up = 1) or by -1 (step_up = 0). The wiper saturates at 0 and at 63. Steps outside this mode have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect, low blocks backup writes |
| cmd_valid | input | 1 | One-cycle pulse: instruction and data bytes valid |
| cmd_instr | input | 8 | Instruction byte |
| cmd_data | input | 8 | Data byte for write commands |
| frame_stop | input | 1 | One-cycle pulse marking end of frame |
| step_valid | input | 1 | One-cycle step pulse in stepping mode |
| step_up | input | 1 | Step direction, 1 = toward top tap |
| ack | output | 1 | Command accepted, one-cycle pulse |
| rd_valid | output | 1 | Read result valid, one-cycle pulse |
| rd_data | output | 8 | Read result, upper two bits zero |
| busy | output | 1 | Programming cycle in progress |
| tap_sel | output | 128 | One-hot tap selects, wiper w at [64*w +: 64] |

## Verification
The outputs ack, rd_valid and rd_data are registered, so each is due in the cycle after the command pulse. Wiper changes from writes, transfers and steps reach tap_sel after that same single edge, because the tap decode is combinational. Busy rises at the frame_stop edge and is counted sample by sample until it falls. The bench drives each pulse for one cycle between falling edges and samples at the next falling edge, which falls exactly on the cycle in which the result is due. For writes that must not take effect, the bench reads the register back through a read command after the frame.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    localparam int unsigned NUM_WIPERS = 2;
    localparam int unsigned NUM_DR     = 4;
    localparam int unsigned VAL_W      = 6;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned IDX_W      = $clog2(NUM_DR);
    localparam int unsigned IMG_W      = NUM_WIPERS * NUM_DR * VAL_W;

    typedef enum logic [3:0] {
        OP_RD_WIPER  = 4'b1001,
        OP_WR_WIPER  = 4'b1010,
        OP_RD_BKP    = 4'b1011,
        OP_WR_BKP    = 4'b1100,
        OP_BKP2WIPER = 4'b1101,
        OP_WIPER2BKP = 4'b1110,
        OP_GANG_LOAD = 4'b0001,
        OP_GANG_SAVE = 4'b1000,
        OP_STEP      = 4'b0010
    } opcode_e;

    typedef struct packed {
        logic             known;
        logic             rd;
        logic             rd_bkp;
        logic             wr_wiper;
        logic             ld_wiper;
        logic             nv;
        logic             nv_from_wiper;
        logic             gang;
        logic             step;
        logic [IDX_W-1:0] idx;
        logic             sel;
    } cmd_t;

    function automatic cmd_t decode_instr(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c      = '0;
        c.idx  = b[3:2];
        c.sel  = b[0];
        if (b[1] == 1'b0) begin
            c.known = 1'b1;
            case (b[7:4])
                OP_RD_WIPER:  c.rd = 1'b1;
                OP_RD_BKP:    begin c.rd = 1'b1; c.rd_bkp = 1'b1; end
                OP_WR_WIPER:  c.wr_wiper = 1'b1;
                OP_WR_BKP:    c.nv = 1'b1;
                OP_BKP2WIPER: c.ld_wiper = 1'b1;
                OP_WIPER2BKP: begin c.nv = 1'b1; c.nv_from_wiper = 1'b1; end
                OP_GANG_LOAD: begin c.ld_wiper = 1'b1; c.gang = 1'b1; end
                OP_GANG_SAVE: begin c.nv = 1'b1; c.nv_from_wiper = 1'b1; c.gang = 1'b1; end
                OP_STEP:      c.step = 1'b1;
                default:      c.known = 1'b0;
            endcase
        end
        return c;
    endfunction

    function automatic logic [IMG_W-1:0] power_on_image();
        logic [IMG_W-1:0] img;
        img = '0;
        for (int w = 0; w < int'(NUM_WIPERS); w++) begin
            for (int i = 0; i < int'(NUM_DR); i++) begin
                img[(w*int'(NUM_DR)+i)*int'(VAL_W) +: VAL_W] = VAL_W'(16*w + 5*i + 3);
            end
        end
        return img;
    endfunction

endpackage

// File: rtl/dwc_decode.sv
module dwc_decode
    import dwc_pkg::*;
(
    input  logic [BYTE_W-1:0] instr,
    input  logic              wp_n,
    output cmd_t              cmd,
    output logic              accept
);
    always_comb begin
        cmd    = decode_instr(instr);
        accept = cmd.known && !(cmd.nv && !wp_n);
    end
endmodule

// File: rtl/dwc_prog_timer.sv
module dwc_prog_timer #(
    parameter int unsigned PROG_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= CNT_W'(PROG_CYCLES);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);
endmodule

// File: rtl/dwc_tap_decode.sv
module dwc_tap_decode #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0]        val,
    output logic [(1<<W)-1:0]   taps
);
    localparam int unsigned TAPS = 1 << W;

    for (genvar t = 0; t < int'(TAPS); t++) begin : g_tap
        assign taps[t] = (val == W'(t));
    end
endmodule

// File: rtl/dwc_regfile.sv
module dwc_regfile
    import dwc_pkg::*;
#(
    parameter int unsigned NW = NUM_WIPERS,
    parameter int unsigned ND = NUM_DR,
    parameter int unsigned W  = VAL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_fire,
    input  cmd_t                 cmd,
    input  logic                 accept,
    input  logic [W-1:0]         data,
    input  logic                 wp_n,
    input  logic                 stop,
    input  logic                 step_valid,
    input  logic                 step_up,
    input  logic                 busy,
    output logic [NW-1:0][W-1:0] wiper,
    output logic                 ack,
    output logic                 rd_valid,
    output logic [BYTE_W-1:0]    rd_data,
    output logic                 nv_start
);
    localparam int unsigned IMGW = NW * ND * W;
    localparam logic [W-1:0] TOP_VAL = '1;

    logic [IMGW-1:0]          bkp_img = power_on_image();
    logic [NW-1:0][W-1:0]     wiper_q;
    logic                     pend_q;
    logic [IDX_W-1:0]         pend_idx_q;
    logic [NW-1:0]            pend_mask_q;
    logic [NW-1:0][W-1:0]     pend_val_q;
    logic                     step_act_q;
    logic                     step_sel_q;

    function automatic logic [W-1:0] bkp_at(input logic [IMGW-1:0] img,
                                            input int w,
                                            input logic [IDX_W-1:0] i);
        return img[(w*int'(ND) + int'(i))*int'(W) +: W];
    endfunction

    assign nv_start = stop && !busy && pend_q && wp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < int'(NW); w++) begin
                wiper_q[w] <= bkp_at(bkp_img, w, '0);
            end
            pend_q      <= 1'b0;
            pend_idx_q  <= '0;
            pend_mask_q <= '0;
            pend_val_q  <= '0;
            step_act_q  <= 1'b0;
            step_sel_q  <= 1'b0;
            ack         <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
        end else begin
            ack      <= 1'b0;
            rd_valid <= 1'b0;

            if (pend_q && !wp_n) begin
                pend_q <= 1'b0;
            end

            if (cmd_fire) begin
                ack        <= accept;
                step_act_q <= 1'b0;
                if (accept) begin
                    if (cmd.rd) begin
                        rd_valid <= 1'b1;
                        rd_data  <= cmd.rd_bkp
                                  ? BYTE_W'(bkp_at(bkp_img, int'(cmd.sel), cmd.idx))
                                  : BYTE_W'(wiper_q[cmd.sel]);
                    end
                    if (cmd.wr_wiper) begin
                        wiper_q[cmd.sel] <= data;
                    end
                    if (cmd.ld_wiper) begin
                        for (int w = 0; w < int'(NW); w++) begin
                            if (cmd.gang || (int'(cmd.sel) == w)) begin
                                wiper_q[w] <= bkp_at(bkp_img, w, cmd.idx);
                            end
                        end
                    end
                    if (cmd.nv) begin
                        pend_q     <= 1'b1;
                        pend_idx_q <= cmd.idx;
                        for (int w = 0; w < int'(NW); w++) begin
                            pend_mask_q[w] <= cmd.gang || (int'(cmd.sel) == w);
                            pend_val_q[w]  <= cmd.nv_from_wiper ? wiper_q[w] : data;
                        end
                    end
                    if (cmd.step) begin
                        step_act_q <= 1'b1;
                        step_sel_q <= cmd.sel;
                    end
                end
            end

            if (stop && !busy) begin
                step_act_q <= 1'b0;
                if (nv_start) begin
                    pend_q <= 1'b0;
                    for (int w = 0; w < int'(NW); w++) begin
                        if (pend_mask_q[w]) begin
                            bkp_img[(w*int'(ND) + int'(pend_idx_q))*int'(W) +: W] <= pend_val_q[w];
                        end
                    end
                end
            end

            if (step_valid && step_act_q && !busy) begin
                if (step_up && (wiper_q[step_sel_q] != TOP_VAL)) begin
                    wiper_q[step_sel_q] <= wiper_q[step_sel_q] + 1'b1;
                end else if (!step_up && (wiper_q[step_sel_q] != '0)) begin
                    wiper_q[step_sel_q] <= wiper_q[step_sel_q] - 1'b1;
                end
            end
        end
    end

    assign wiper = wiper_q;
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
    import dwc_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 250000,
    parameter int unsigned NW          = NUM_WIPERS,
    parameter int unsigned W           = VAL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wp_n,
    input  logic                     cmd_valid,
    input  logic [7:0]               cmd_instr,
    input  logic [7:0]               cmd_data,
    input  logic                     frame_stop,
    input  logic                     step_valid,
    input  logic                     step_up,
    output logic                     ack,
    output logic                     rd_valid,
    output logic [7:0]               rd_data,
    output logic                     busy,
    output logic [NW*(1<<W)-1:0]     tap_sel
);
    localparam int unsigned TAPS = 1 << W;

    cmd_t                 cmd;
    logic                 accept;
    logic                 nv_start;
    logic [NW-1:0][W-1:0] wiper;
    logic                 unused_hi;

    assign unused_hi = ^cmd_data[7:W];

    dwc_decode u_decode (
        .instr  (cmd_instr),
        .wp_n   (wp_n),
        .cmd    (cmd),
        .accept (accept)
    );

    dwc_regfile #(.NW(NW), .ND(NUM_DR), .W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cmd_fire   (cmd_valid && !busy),
        .cmd        (cmd),
        .accept     (accept),
        .data       (cmd_data[W-1:0]),
        .wp_n       (wp_n),
        .stop       (frame_stop),
        .step_valid (step_valid),
        .step_up    (step_up),
        .busy       (busy),
        .wiper      (wiper),
        .ack        (ack),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .nv_start   (nv_start)
    );

    dwc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (nv_start),
        .busy  (busy)
    );

    for (genvar w = 0; w < int'(NW); w++) begin : g_wiper
        dwc_tap_decode #(.W(W)) u_taps (
            .val  (wiper[w]),
            .taps (tap_sel[w*int'(TAPS) +: TAPS])
        );
    end
endmodule

// File: rtl/dual_wiper_ctrl_chk.sv
module dual_wiper_ctrl_chk #(
    parameter int unsigned PROG_CYCLES = 250000,
    parameter int unsigned NW          = 2,
    parameter int unsigned W           = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic                 frame_stop,
    input logic                 ack,
    input logic                 rd_valid,
    input logic [7:0]           rd_data,
    input logic                 busy,
    input logic [NW*(1<<W)-1:0] tap_sel
);
    localparam int unsigned TAPS  = 1 << W;
    localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 2);

    logic [CNT_W-1:0] busy_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run_q <= '0;
        end else if (busy) begin
            busy_run_q <= busy_run_q + 1'b1;
        end else begin
            busy_run_q <= '0;
        end
    end

    for (genvar w = 0; w < int'(NW); w++) begin : g_onehot
        p_tap_onehot_r10: assert property (@(posedge clk) disable iff (rst)
            $countones(tap_sel[w*int'(TAPS) +: TAPS]) == 1);
    end

    p_rd_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[7:6] == 2'b00));

    p_busy_mutes_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> (!ack && !rd_valid));

    p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(frame_stop));

    p_busy_not_long_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run_q < CNT_W'(PROG_CYCLES)));

    p_busy_full_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run_q == CNT_W'(PROG_CYCLES)));
endmodule

bind dual_wiper_ctrl dual_wiper_ctrl_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .NW          (NW),
    .W           (W)
) u_chk (.*);

// File: tb/dual_wiper_ctrl_bench.sv
module dual_wiper_ctrl_bench;
    localparam int PROG = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wp_n = 1'b1;
    logic         cmd_valid = 1'b0;
    logic [7:0]   cmd_instr = '0;
    logic [7:0]   cmd_data = '0;
    logic         frame_stop = 1'b0;
    logic         step_valid = 1'b0;
    logic         step_up = 1'b0;
    logic         ack;
    logic         rd_valid;
    logic [7:0]   rd_data;
    logic         busy;
    logic [127:0] tap_sel;

    int tests  = 0;
    int failed = 0;
    int exp_w [2];
    int exp_dr [2][4];
    logic s_ack, s_rdv;
    int   s_rd;

    always #10 clk = ~clk;

    dual_wiper_ctrl #(.PROG_CYCLES(PROG)) u_dual_wiper_ctrl (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_taps(input string tag);
        for (int w = 0; w < 2; w++) begin
            logic [63:0] got, want;
            got  = tap_sel[w*64 +: 64];
            want = 64'd1 << exp_w[w];
            tests++;
            if (got !== want) begin
                failed++;
                $display("FAIL %s/R10 wiper%0d taps actual=%h expected=%h", tag, w, got, want);
            end
        end
    endtask

    task automatic send(input logic [7:0] ins, input logic [7:0] dat);
        @(negedge clk);
        cmd_instr = ins; cmd_data = dat; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        s_ack = ack; s_rdv = rd_valid; s_rd = int'(rd_data);
    endtask

    task automatic stop_frame();
        @(negedge clk);
        frame_stop = 1'b1;
        @(negedge clk);
        frame_stop = 1'b0;
    endtask

    task automatic step(input logic up);
        @(negedge clk);
        step_valid = 1'b1; step_up = up;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic count_busy(input string tag);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == PROG, tag, n, PROG);
    endtask

    task automatic read_bkp(input int w, input int i, input string tag);
        send(8'(8'hB0 | (i << 2) | w), 8'h00);
        chk(s_ack && s_rdv, {tag, " read ack"}, int'(s_ack), 1);
        chk(s_rd == exp_dr[w][i], tag, s_rd, exp_dr[w][i]);
    endtask

    task automatic t_reset();
        check_taps("R1 reset recall");
        send(8'h90, 8'h00);
        chk(s_rdv && s_rd == exp_w[0], "R2 read wiper0", s_rd, exp_w[0]);
        send(8'h91, 8'h00);
        chk(s_rdv && s_rd == exp_w[1], "R2 read wiper1", s_rd, exp_w[1]);
        stop_frame();
    endtask

    task automatic t_wiper_rw();
        send(8'hA0, 8'hE5); exp_w[0] = 37;
        chk(s_ack == 1'b1, "R3 write ack", int'(s_ack), 1);
        check_taps("R3 write wiper0");
        send(8'h90, 8'h00);
        chk(s_rd == 37, "R2 readback upper bits zero", s_rd, 37);
        send(8'hA1, 8'h0A); exp_w[1] = 10;
        check_taps("R3 write wiper1");
        stop_frame();
        chk(busy == 1'b0, "R3 no busy", int'(busy), 0);
    endtask

    task automatic t_bkp_rw();
        send(8'hC9, 8'h3F);
        chk(s_ack == 1'b1, "R4 write ack", int'(s_ack), 1);
        chk(busy == 1'b0, "R4 no busy before stop", int'(busy), 0);
        stop_frame(); exp_dr[1][2] = 63;
        chk(busy == 1'b1, "R4 busy after stop", int'(busy), 1);
        count_busy("R4 busy length");
        read_bkp(1, 2, "R4 read written");
        read_bkp(0, 0, "R4 other untouched");
        stop_frame();
        check_taps("R4 wipers unchanged");
    endtask

    task automatic t_xfer();
        send(8'hD4, 8'h00); exp_w[0] = exp_dr[0][1];
        check_taps("R5 bkp to wiper");
        stop_frame();
        chk(busy == 1'b0, "R5 load no busy", int'(busy), 0);
        send(8'hED, 8'h00); exp_dr[1][3] = exp_w[1];
        stop_frame();
        count_busy("R5 save busy");
        read_bkp(1, 3, "R5 wiper to bkp");
        stop_frame();
    endtask

    task automatic t_gang();
        send(8'h19, 8'h00); exp_w[0] = exp_dr[0][2]; exp_w[1] = exp_dr[1][2];
        check_taps("R6 gang load");
        stop_frame();
        chk(busy == 1'b0, "R6 gang load no busy", int'(busy), 0);
        send(8'hA0, 8'h05); exp_w[0] = 5;
        send(8'hA1, 8'h06); exp_w[1] = 6;
        send(8'h81, 8'h00); exp_dr[0][0] = 5; exp_dr[1][0] = 6;
        stop_frame();
        count_busy("R6 gang save busy");
        read_bkp(0, 0, "R6 gang save w0");
        read_bkp(1, 0, "R6 gang save w1");
        read_bkp(0, 1, "R6 other index kept");
        stop_frame();
    endtask

    task automatic t_protect();
        wp_n = 1'b0;
        send(8'hC0, 8'h11);
        chk(s_ack == 1'b0, "R7 protected write nack", int'(s_ack), 0);
        stop_frame();
        chk(busy == 1'b0, "R7 protected no busy", int'(busy), 0);
        send(8'hE0, 8'h00);
        chk(s_ack == 1'b0, "R7 protected save nack", int'(s_ack), 0);
        stop_frame();
        read_bkp(0, 0, "R7 bkp unchanged");
        send(8'hA0, 8'h30); exp_w[0] = 48;
        chk(s_ack == 1'b1, "R7 wiper write allowed", int'(s_ack), 1);
        check_taps("R7 wiper write allowed");
        stop_frame();
        wp_n = 1'b1;
    endtask

    task automatic t_protect_mid();
        send(8'hC1, 8'h22);
        chk(s_ack == 1'b1, "R8 ack before drop", int'(s_ack), 1);
        @(negedge clk); wp_n = 1'b0;
        @(negedge clk); wp_n = 1'b1;
        stop_frame();
        chk(busy == 1'b0, "R8 dropped no busy", int'(busy), 0);
        read_bkp(1, 0, "R8 dropped write");
        stop_frame();
        send(8'hC1, 8'h22);
        stop_frame(); exp_dr[1][0] = 34;
        chk(busy == 1'b1, "R8 started", int'(busy), 1);
        wp_n = 1'b0;
        count_busy("R8 busy with wp low");
        wp_n = 1'b1;
        read_bkp(1, 0, "R8 write completes");
        stop_frame();
    endtask

    task automatic t_busy();
        send(8'hC5, 8'h07); exp_dr[1][1] = 7;
        stop_frame();
        send(8'h90, 8'h00);
        chk(!s_ack && !s_rdv, "R9 read ignored while busy", int'(s_ack), 0);
        send(8'hA0, 8'h01);
        chk(s_ack == 1'b0, "R9 write ignored while busy", int'(s_ack), 0);
        check_taps("R9 wiper untouched while busy");
        while (busy) @(negedge clk);
        read_bkp(1, 1, "R9 busy write landed");
        stop_frame();
    endtask

    task automatic t_unknown();
        send(8'h50, 8'h3F);
        chk(s_ack == 1'b0, "R11 opcode 0101 nack", int'(s_ack), 0);
        send(8'h30, 8'h3F);
        chk(s_ack == 1'b0, "R11 opcode 0011 nack", int'(s_ack), 0);
        send(8'hA2, 8'h01);
        chk(s_ack == 1'b0, "R11 bit1 set nack", int'(s_ack), 0);
        check_taps("R11 no wiper change");
        stop_frame();
        chk(busy == 1'b0, "R11 no busy", int'(busy), 0);
        read_bkp(0, 0, "R11 bkp unchanged");
        stop_frame();
    endtask

    task automatic t_step();
        step(1'b1);
        check_taps("R12 step outside mode ignored");
        send(8'hA1, 8'd62); exp_w[1] = 62;
        send(8'h21, 8'h00);
        chk(s_ack == 1'b1, "R12 step cmd ack", int'(s_ack), 1);
        step(1'b1); exp_w[1] = 63;
        check_taps("R12 step up");
        step(1'b1);
        check_taps("R12 saturate top");
        step(1'b0); exp_w[1] = 62;
        check_taps("R12 step down");
        stop_frame();
        step(1'b1);
        check_taps("R12 step after stop ignored");
        send(8'hA0, 8'h01); exp_w[0] = 1;
        send(8'h20, 8'h00);
        step(1'b0); exp_w[0] = 0;
        step(1'b0);
        check_taps("R12 saturate bottom");
        stop_frame();
    endtask

    task automatic t_recall();
        send(8'hC0, 8'h2A); exp_dr[0][0] = 42;
        stop_frame();
        while (busy) @(negedge clk);
        send(8'hA0, 8'h09);
        stop_frame();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_w[0] = exp_dr[0][0]; exp_w[1] = exp_dr[1][0];
        check_taps("R1 recall after reset");
        chk(busy == 1'b0, "R1 reset busy low", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 4; i++)
                exp_dr[w][i] = 16*w + 5*i + 3;
        exp_w[0] = exp_dr[0][0];
        exp_w[1] = exp_dr[1][0];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!ack && !rd_valid && !busy, "R1 reset outputs idle", int'(busy), 0);
        t_reset();
        t_wiper_rw();
        t_bkp_rw();
        t_xfer();
        t_gang();
        t_protect();
        t_protect_mid();
        t_busy();
        t_unknown();
        t_step();
        t_recall();
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule